// File: doc/BRIEF.md
# Channel Request Queue with Idle-Count Accumulators

This block takes channel identifier requests from a client over a valid/ready handshake and holds them in an internal queue. A downstream channelized consumer drains the queue one entry per pop strobe. Ready does not follow full or empty. It follows a fixed occupancy limit below the queue depth, so requests that are already in flight when ready falls still find room.

Each accepted request also carries a 6-bit adjustment. A non-zero adjustment is added to a per-channel 16-bit idle-count accumulator in the same cycle as the enqueue. A separate read port returns any accumulator's value one cycle after its index is presented.

Top module: `chq_top`

## Requirements
- R1: After reset, `req_ready` is high, `deq_valid` is low and every accumulator reads zero.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. A request presented while `req_ready` is low is not queued, and its adjustment is dropped.
- R3: `req_ready` is high exactly when the queue holds 8 or fewer entries. Queue depth is 16.
- R4: `deq_valid` is high whenever the queue is non-empty. `deq_chan` is the oldest queued channel, so channels leave in arrival order.
- R5: A pop while the queue is empty changes nothing.
- R6: An accepted request whose adjustment is 0 leaves the addressed accumulator unchanged.
- R7: An accepted request with a non-zero adjustment adds that amount (1 to 63) to the accumulator of the channel in `req_chan`.
- R8: Accumulators saturate at 65535 and do not wrap.
- R9: `acc_data` shows, one cycle later, the value that the accumulator selected by `acc_idx` held in the cycle the index was presented. An update in that same cycle is not yet visible.
- R10: A push and a pop in the same cycle leave the occupancy unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Queue can take a request |
| req_chan | input | 6 | Requested channel ID |
| req_adj | input | 6 | Accumulator adjustment amount |
| deq_valid | output | 1 | Queue head is valid |
| deq_chan | output | 6 | Channel ID at the queue head |
| deq_pop | input | 1 | Consumer removes the head |
| acc_idx | input | 6 | Accumulator read index |
| acc_data | output | 16 | Accumulator value, one cycle latency |

## Verification
The bench fills the queue with no pops until ready falls at nine entries. It keeps requesting while ready is low: a design that enqueued those requests, or applied their adjustments, would show extra head entries or accumulator growth. Pops against an empty queue catch pointer or count underflow, which would surface as a spurious `deq_valid`. A single channel is pushed past 65535 to expose wrap-around. Reads of a channel while that same channel is being updated catch a read port that returns the new value a cycle early.

// File: rtl/chq_pkg.sv
package chq_pkg;
    localparam int CHQ_CH_W   = 6;
    localparam int CHQ_ADJ_W  = 6;
    localparam int CHQ_ACC_W  = 16;
    localparam int CHQ_DEPTH  = 16;
    localparam int CHQ_THRESH = 8;
endpackage

// File: rtl/chq_fifo.sv
module chq_fifo #(
    parameter int W      = chq_pkg::CHQ_CH_W,
    parameter int DEPTH  = chq_pkg::CHQ_DEPTH,
    parameter int THRESH = chq_pkg::CHQ_THRESH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         head_valid,
    output logic [W-1:0] head_data,
    output logic         below_limit
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && (st_q.cnt != CW'(DEPTH));
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_valid  = (st_q.cnt != '0);
    assign head_data   = st_q.mem[st_q.rd];
    assign below_limit = (st_q.cnt <= CW'(THRESH));
endmodule

// File: rtl/chq_acc_bank.sv
module chq_acc_bank #(
    parameter int CH_W  = chq_pkg::CHQ_CH_W,
    parameter int ADJ_W = chq_pkg::CHQ_ADJ_W,
    parameter int ACC_W = chq_pkg::CHQ_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [CH_W-1:0]  upd_ch,
    input  logic [ADJ_W-1:0] upd_amt,
    input  logic [CH_W-1:0]  rd_idx,
    output logic [ACC_W-1:0] rd_data
);
    localparam int NCH = 1 << CH_W;

    typedef struct packed {
        logic [NCH-1:0][ACC_W-1:0] acc;
        logic [ACC_W-1:0]          rd;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [NCH-1:0]   hit;
    logic [ACC_W:0]   sum [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign hit[c] = upd_en && (upd_amt != '0) && (upd_ch == CH_W'(c));
        assign sum[c] = {1'b0, st_q.acc[c]} + (ACC_W + 1)'(upd_amt);
    end

    always_comb begin
        st_d    = st_q;
        st_d.rd = st_q.acc[rd_idx];
        for (int c = 0; c < NCH; c++) begin
            if (hit[c]) st_d.acc[c] = sum[c][ACC_W] ? '1 : sum[c][ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd;
endmodule

// File: rtl/chq_top.sv
module chq_top #(
    parameter int CH_W   = chq_pkg::CHQ_CH_W,
    parameter int ADJ_W  = chq_pkg::CHQ_ADJ_W,
    parameter int ACC_W  = chq_pkg::CHQ_ACC_W,
    parameter int DEPTH  = chq_pkg::CHQ_DEPTH,
    parameter int THRESH = chq_pkg::CHQ_THRESH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CH_W-1:0]  req_chan,
    input  logic [ADJ_W-1:0] req_adj,
    output logic             deq_valid,
    output logic [CH_W-1:0]  deq_chan,
    input  logic             deq_pop,
    input  logic [CH_W-1:0]  acc_idx,
    output logic [ACC_W-1:0] acc_data
);
    logic take;

    assign take = req_valid && req_ready;

    chq_fifo #(.W(CH_W), .DEPTH(DEPTH), .THRESH(THRESH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (take),
        .push_data  (req_chan),
        .pop        (deq_pop),
        .head_valid (deq_valid),
        .head_data  (deq_chan),
        .below_limit(req_ready)
    );

    chq_acc_bank #(.CH_W(CH_W), .ADJ_W(ADJ_W), .ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd_en (take),
        .upd_ch (req_chan),
        .upd_amt(req_adj),
        .rd_idx (acc_idx),
        .rd_data(acc_data)
    );
endmodule

// File: rtl/chq_checker.sv
module chq_checker #(
    parameter int CH_W  = 6,
    parameter int ADJ_W = 6,
    parameter int ACC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [CH_W-1:0]  req_chan,
    input logic [ADJ_W-1:0] req_adj,
    input logic             deq_valid,
    input logic [CH_W-1:0]  deq_chan,
    input logic             deq_pop,
    input logic [CH_W-1:0]  acc_idx,
    input logic [ACC_W-1:0] acc_data
);
    AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !deq_valid)); // R1

    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(deq_pop && deq_valid)) |=> deq_valid); // R2

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !deq_pop) |=> (deq_valid && $stable(deq_chan))); // R4

    AST_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!deq_valid && !(req_valid && req_ready)) |=> !deq_valid); // R5

    AST_ACC_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_idx) == acc_idx) |=> (acc_data >= $past(acc_data))); // R8

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(acc_idx) == acc_idx) &&
         !$past(req_valid && req_ready && (req_adj != '0) && (req_chan == acc_idx)))
        |=> $stable(acc_data)); // R9
endmodule

bind chq_top chq_checker #(.CH_W(CH_W), .ADJ_W(ADJ_W), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_adj(req_adj), .deq_valid(deq_valid),
    .deq_chan(deq_chan), .deq_pop(deq_pop), .acc_idx(acc_idx), .acc_data(acc_data)
);

// File: tb/tb_chq_top.sv
module tb_chq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_chan = '0;
    logic [5:0]  req_adj = '0;
    logic        deq_valid;
    logic [5:0]  deq_chan;
    logic        deq_pop = 1'b0;
    logic [5:0]  acc_idx = '0;
    logic [15:0] acc_data;

    int    n_chk = 0;
    int    n_bad = 0;
    int    q[$];
    int    acc_m[64];
    int    rd_m = 0;
    string ph = "";

    always #10 clk = ~clk;

    chq_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_adj(req_adj), .deq_valid(deq_valid),
        .deq_chan(deq_chan), .deq_pop(deq_pop), .acc_idx(acc_idx), .acc_data(acc_data)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, ph, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R3 ready", int'(req_ready), int'(q.size() <= 8));
        check("R4 deq_valid", int'(deq_valid), int'(q.size() > 0));
        if (q.size() > 0) check("R4 deq_chan", int'(deq_chan), q[0]);
        check("R9 acc_data", int'(acc_data), rd_m);
    endtask

    task automatic cyc(input bit v, input int ch, input int adj, input bit p, input int idx);
        bit rdy, take;
        req_valid = v; req_chan = 6'(ch); req_adj = 6'(adj);
        deq_pop = p; acc_idx = 6'(idx);
        @(posedge clk);
        rdy  = (q.size() <= 8);
        take = v && rdy;
        rd_m = acc_m[idx];
        if (p && q.size() > 0) void'(q.pop_front());
        if (take) q.push_back(ch);
        if (take && adj != 0) acc_m[ch] = (acc_m[ch] + adj > 65535) ? 65535 : acc_m[ch] + adj;
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        foreach (acc_m[i]) acc_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ph = "R1 reset state";
        check("R1 ready", int'(req_ready), 1);
        check("R1 deq_valid", int'(deq_valid), 0);
        check("R1 acc_data", int'(acc_data), 0);
        for (int c = 0; c < 64; c++) cyc(0, 0, 0, 0, c);

        ph = "R5 pop on empty";
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 3);
        check("R5 deq_valid", int'(deq_valid), 0);

        ph = "R2 R3 fill past limit, requests while not ready";
        for (int i = 0; i < 14; i++) cyc(1, i + 10, 7, 0, i + 10);
        check("R3 ready low at 9", int'(req_ready), 0);
        for (int i = 0; i < 6; i++) cyc(1, 40, 9, 0, 40);
        check("R2 dropped adj", int'(acc_data), 0);

        ph = "R4 drain order";
        for (int i = 0; i < 12; i++) cyc(0, 0, 0, 1, 10);
        check("R4 empty after drain", int'(deq_valid), 0);

        ph = "R6 zero adjust";
        cyc(1, 20, 0, 1, 20);
        cyc(0, 0, 0, 1, 20);
        cyc(0, 0, 0, 0, 20);
        check("R6 acc unchanged", int'(acc_data), 0);

        ph = "R7 add and R9 same-cycle read";
        cyc(1, 21, 5, 1, 21);
        check("R9 old value", int'(acc_data), 0);
        cyc(1, 21, 63, 1, 21);
        check("R7 first add", int'(acc_data), 5);
        cyc(0, 0, 0, 1, 21);
        check("R7 sum", int'(acc_data), 68);

        ph = "R10 simultaneous push and pop";
        cyc(1, 1, 1, 0, 1);
        cyc(1, 2, 1, 0, 1);
        for (int i = 0; i < 30; i++) cyc(1, i, i, 1, i);

        ph = "R8 saturation";
        for (int i = 0; i < 1100; i++) cyc(1, 5, 63, 1, 5);
        cyc(0, 0, 0, 1, 5);
        check("R8 saturated", int'(acc_data), 65535);

        ph = "R3 random traffic";
        for (int i = 0; i < 3000; i++)
            cyc(1'($urandom % 4 != 0), int'($urandom % 64), int'($urandom % 64),
                1'($urandom % 2), int'($urandom % 64));
        finish_run();
    end
endmodule